// File: doc/BRIEF.md
# MII Transceiver Control Register with Isolation

This block holds the main control bits of a 10/100 Ethernet transceiver and applies them to the MII data path. A management interface writes and reads one 16-bit control word through a plain parallel port. The implemented fields are auto-negotiation enable, isolate, restart negotiation, duplex select and collision test. The block gates the MAC transmit inputs into the transceiver core. It produces an output-enable vector for every MII output the transceiver drives. It gives the negotiation engine a one-clock restart pulse and resolves the effective duplex setting.

The isolate bit takes its reset value from a strapped PHY address. That address is sampled while reset is asserted. An all-zero address starts the device isolated, so on a shared bus only the parts that are given an address take part. In collision-test mode the block loops the transmit-enable input back onto the collision output after a fixed delay counted in transmit clocks. One MII clock carries one nibble, so one clock is four bit times.

Top module: `phy_ctrl_reg`

## Requirements
- R1: Reset is synchronous. While `rst_n` is low, every control bit clears except isolate (bit 10). Isolate resets to 1 when `phy_addr_strap` is 5'b00000 and to 0 otherwise.
- R2: With isolate set, `mii_oe` is all zeros. `line_tx_en`, `line_tx_er` and `line_txd` are 0 whatever the MAC inputs are. With isolate clear, `mii_oe` is all ones and the MAC transmit inputs pass to the line side unchanged in the same cycle. `mii_oe` bit map: 0 transmit clock, 1 receive clock, 2 receive valid, 3 receive error, 4 receive data, 5 collision, 6 carrier sense.
- R3: The register stays readable and writable while isolated. Writing 0 to bit 10 ends isolation.
- R4: A write with bit 9 set makes bit 9 read 1 from the next cycle. One cycle later `an_restart_pulse` is high for exactly one clock. Bit 9 reads 0 from the cycle after the pulse. Writing 0 to bit 9 has no effect on a pending restart.
- R5: A restart write that lands in the same cycle as an active pulse is not lost. It produces a second pulse two cycles after the first.
- R6: `duplex_full` equals `an_result_full` when bit 12 (negotiation enable) is 1. Otherwise it equals bit 8 (duplex select).
- R7: With bit 7 (collision test) set, `mii_col` follows the gated transmit enable delayed by `COL_STAGES` clocks (default 1). With bit 7 clear, `mii_col` equals `core_col`.
- R8: In collision-test mode while isolated, MAC transmit enable is ignored and `mii_col` stays 0.
- R9: Bits 15, 14, 13, 11 and 6 to 0 always read 0, and writes to them are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MII transmit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phy_addr_strap | input | 5 | Strapped PHY address, sampled during reset |
| reg_wr_en | input | 1 | Control word write strobe |
| reg_wr_data | input | 16 | Control word write data |
| reg_rd_data | output | 16 | Control word read data |
| an_result_full | input | 1 | Negotiated duplex from the negotiation engine (1 = full) |
| an_restart_pulse | output | 1 | One-clock restart request to the negotiation engine |
| duplex_full | output | 1 | Effective duplex in use |
| mac_txd | input | 4 | MAC transmit nibble |
| mac_tx_en | input | 1 | MAC transmit enable |
| mac_tx_er | input | 1 | MAC transmit error |
| line_txd | output | 4 | Gated transmit nibble to the transceiver core |
| line_tx_en | output | 1 | Gated transmit enable to the core |
| line_tx_er | output | 1 | Gated transmit error to the core |
| core_rxd | input | 4 | Receive nibble from the core |
| core_rx_dv | input | 1 | Receive valid from the core |
| core_rx_er | input | 1 | Receive error from the core |
| core_crs | input | 1 | Carrier sense from the core |
| core_col | input | 1 | Collision detect from the core |
| mii_rxd | output | 4 | Receive nibble to the MII pins |
| mii_rx_dv | output | 1 | Receive valid to the MII pins |
| mii_rx_er | output | 1 | Receive error to the MII pins |
| mii_crs | output | 1 | Carrier sense to the MII pins |
| mii_col | output | 1 | Collision, or looped transmit enable in test mode |
| mii_oe | output | 7 | Output enables for the MII outputs (map in R2) |

## Verification
The self-clearing restart bit and a fresh restart write can arrive in the same cycle. The write then meets the clock edge at which the pulse ends and the bit would clear. The bench provokes this by issuing a second restart write in exactly the cycle where the first pulse is high. It then requires bit 9 to stay at 1 and a second single-cycle pulse to follow two clocks after the first. A second overlap is an isolate write while collision test is running with transmit enable high. For that case the bench requires the looped collision to fall and stay low.

// File: rtl/phy_ctrl_pkg.sv
package phy_ctrl_pkg;
    localparam int CTRL_W   = 16;
    localparam int B_ANEN   = 12;
    localparam int B_ISO    = 10;
    localparam int B_RESTRT = 9;
    localparam int B_DUPLEX = 8;
    localparam int B_COLTST = 7;
    localparam int ADDR_W   = 5;
    localparam int NIB_W    = 4;

    localparam int OE_TXCLK = 0;
    localparam int OE_RXCLK = 1;
    localparam int OE_RXDV  = 2;
    localparam int OE_RXER  = 3;
    localparam int OE_RXD   = 4;
    localparam int OE_COL   = 5;
    localparam int OE_CRS   = 6;
    localparam int OE_W     = 7;

    typedef struct packed {
        logic an_en;
        logic iso;
        logic restart;
        logic duplex;
        logic coltest;
        logic pulse;
    } ctrl_t;
endpackage

// File: rtl/phy_ctrl_regs.sv
module phy_ctrl_regs
    import phy_ctrl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   strap,
    input  logic                wr_en,
    input  logic [CTRL_W-1:0]   wr_data,
    output ctrl_t               ctrl,
    output logic [CTRL_W-1:0]   rd_data
);
    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // restart: held until one pulse has been issued, then self-clears
        st_d.pulse   = st_q.restart & ~st_q.pulse;
        st_d.restart = st_q.restart & ~st_q.pulse;
        if (wr_en) begin
            st_d.an_en   = wr_data[B_ANEN];
            st_d.iso     = wr_data[B_ISO];
            st_d.duplex  = wr_data[B_DUPLEX];
            st_d.coltest = wr_data[B_COLTST];
            if (wr_data[B_RESTRT]) begin
                st_d.restart = 1'b1;
            end
        end
        if (!rst_n) begin
            st_d     = '0;
            st_d.iso = (strap == '0);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        rd_data           = '0;
        rd_data[B_ANEN]   = st_q.an_en;
        rd_data[B_ISO]    = st_q.iso;
        rd_data[B_RESTRT] = st_q.restart;
        rd_data[B_DUPLEX] = st_q.duplex;
        rd_data[B_COLTST] = st_q.coltest;
    end

    assign ctrl = st_q;
endmodule

// File: rtl/phy_col_echo.sv
module phy_col_echo #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en_in,
    output logic echo
);
    logic [STAGES-1:0] sr_d, sr_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb begin
                sr_d = tx_en_in;
                if (!rst_n) sr_d = '0;
            end
        end else begin : g_many
            always_comb begin
                sr_d = {sr_q[STAGES-2:0], tx_en_in};
                if (!rst_n) sr_d = '0;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        sr_q <= sr_d;
    end

    assign echo = sr_q[STAGES-1];
endmodule

// File: rtl/phy_mii_gate.sv
module phy_mii_gate
    import phy_ctrl_pkg::*;
(
    input  logic              iso,
    input  logic              coltest,
    input  logic              echo,
    input  logic [NIB_W-1:0]  mac_txd,
    input  logic              mac_tx_en,
    input  logic              mac_tx_er,
    input  logic [NIB_W-1:0]  core_rxd,
    input  logic              core_rx_dv,
    input  logic              core_rx_er,
    input  logic              core_crs,
    input  logic              core_col,
    output logic [NIB_W-1:0]  line_txd,
    output logic              line_tx_en,
    output logic              line_tx_er,
    output logic [NIB_W-1:0]  mii_rxd,
    output logic              mii_rx_dv,
    output logic              mii_rx_er,
    output logic              mii_crs,
    output logic              mii_col,
    output logic [OE_W-1:0]   mii_oe
);
    assign line_txd   = iso ? '0 : mac_txd;
    assign line_tx_en = ~iso & mac_tx_en;
    assign line_tx_er = ~iso & mac_tx_er;

    assign mii_rxd    = core_rxd;
    assign mii_rx_dv  = core_rx_dv;
    assign mii_rx_er  = core_rx_er;
    assign mii_crs    = core_crs;
    assign mii_col    = coltest ? echo : core_col;

    genvar i;
    generate
        for (i = 0; i < OE_W; i++) begin : g_oe
            assign mii_oe[i] = ~iso;
        end
    endgenerate
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
    import phy_ctrl_pkg::*;
#(
    parameter int COL_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        phy_addr_strap,
    input  logic              reg_wr_en,
    input  logic [15:0]       reg_wr_data,
    output logic [15:0]       reg_rd_data,
    input  logic              an_result_full,
    output logic              an_restart_pulse,
    output logic              duplex_full,
    input  logic [3:0]        mac_txd,
    input  logic              mac_tx_en,
    input  logic              mac_tx_er,
    output logic [3:0]        line_txd,
    output logic              line_tx_en,
    output logic              line_tx_er,
    input  logic [3:0]        core_rxd,
    input  logic              core_rx_dv,
    input  logic              core_rx_er,
    input  logic              core_crs,
    input  logic              core_col,
    output logic [3:0]        mii_rxd,
    output logic              mii_rx_dv,
    output logic              mii_rx_er,
    output logic              mii_crs,
    output logic              mii_col,
    output logic [6:0]        mii_oe
);
    ctrl_t ctrl;
    logic  echo;

    phy_ctrl_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .strap   (phy_addr_strap),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .ctrl    (ctrl),
        .rd_data (reg_rd_data)
    );

    phy_col_echo #(.STAGES(COL_STAGES)) u_echo (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en_in (line_tx_en),
        .echo     (echo)
    );

    phy_mii_gate u_gate (
        .iso        (ctrl.iso),
        .coltest    (ctrl.coltest),
        .echo       (echo),
        .mac_txd    (mac_txd),
        .mac_tx_en  (mac_tx_en),
        .mac_tx_er  (mac_tx_er),
        .core_rxd   (core_rxd),
        .core_rx_dv (core_rx_dv),
        .core_rx_er (core_rx_er),
        .core_crs   (core_crs),
        .core_col   (core_col),
        .line_txd   (line_txd),
        .line_tx_en (line_tx_en),
        .line_tx_er (line_tx_er),
        .mii_rxd    (mii_rxd),
        .mii_rx_dv  (mii_rx_dv),
        .mii_rx_er  (mii_rx_er),
        .mii_crs    (mii_crs),
        .mii_col    (mii_col),
        .mii_oe     (mii_oe)
    );

    assign an_restart_pulse = ctrl.pulse;
    assign duplex_full      = ctrl.an_en ? an_result_full : ctrl.duplex;
endmodule

// File: rtl/phy_ctrl_reg_chk.sv
module phy_ctrl_reg_chk #(
    parameter int COL_STAGES = 1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic [15:0] reg_wr_data,
    input logic [15:0] reg_rd_data,
    input logic        an_restart_pulse,
    input logic [6:0]  mii_oe,
    input logic        line_tx_en,
    input logic        line_tx_er,
    input logic [3:0]  line_txd,
    input logic        mii_col
);
    // R2
    iso_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_data[10] |-> (mii_oe == 7'd0 && !line_tx_en && !line_tx_er && line_txd == 4'd0));

    // R4
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        an_restart_pulse |=> !an_restart_pulse);

    // R4
    restart_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wr_data[9]) |=> reg_rd_data[9]);

    // R4
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (an_restart_pulse && !(reg_wr_en && reg_wr_data[9])) |=> !reg_rd_data[9]);

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data[6:0] == 7'd0 && reg_rd_data[15:13] == 3'd0 && !reg_rd_data[11]));

    generate
        if (COL_STAGES == 1) begin : g_col
            // R7
            col_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_rd_data[7] && $past(reg_rd_data[7]) && $past(rst_n)) |-> (mii_col == $past(line_tx_en)));
        end
    endgenerate
endmodule

bind phy_ctrl_reg phy_ctrl_reg_chk #(.COL_STAGES(COL_STAGES)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .reg_wr_en        (reg_wr_en),
    .reg_wr_data      (reg_wr_data),
    .reg_rd_data      (reg_rd_data),
    .an_restart_pulse (an_restart_pulse),
    .mii_oe           (mii_oe),
    .line_tx_en       (line_tx_en),
    .line_tx_er       (line_tx_er),
    .line_txd         (line_txd),
    .mii_col          (mii_col)
);

// File: tb/phy_ctrl_reg_tb.sv
`timescale 1ns/1ps
module phy_ctrl_reg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  phy_addr_strap = 5'h03;
    logic        reg_wr_en = 1'b0;
    logic [15:0] reg_wr_data = '0;
    logic [15:0] reg_rd_data;
    logic        an_result_full = 1'b0;
    logic        an_restart_pulse;
    logic        duplex_full;
    logic [3:0]  mac_txd = '0;
    logic        mac_tx_en = 1'b0;
    logic        mac_tx_er = 1'b0;
    logic [3:0]  line_txd;
    logic        line_tx_en, line_tx_er;
    logic [3:0]  core_rxd = 4'h5;
    logic        core_rx_dv = 1'b1, core_rx_er = 1'b0, core_crs = 1'b1, core_col = 1'b0;
    logic [3:0]  mii_rxd;
    logic        mii_rx_dv, mii_rx_er, mii_crs, mii_col;
    logic [6:0]  mii_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    phy_ctrl_reg u_dut (
        .clk(clk), .rst_n(rst_n), .phy_addr_strap(phy_addr_strap),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
        .an_result_full(an_result_full), .an_restart_pulse(an_restart_pulse),
        .duplex_full(duplex_full), .mac_txd(mac_txd), .mac_tx_en(mac_tx_en),
        .mac_tx_er(mac_tx_er), .line_txd(line_txd), .line_tx_en(line_tx_en),
        .line_tx_er(line_tx_er), .core_rxd(core_rxd), .core_rx_dv(core_rx_dv),
        .core_rx_er(core_rx_er), .core_crs(core_crs), .core_col(core_col),
        .mii_rxd(mii_rxd), .mii_rx_dv(mii_rx_dv), .mii_rx_er(mii_rx_er),
        .mii_crs(mii_crs), .mii_col(mii_col), .mii_oe(mii_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one write, leaves time just after the capturing edge
    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wr_data = d;
        @(posedge clk);
        #1;
        reg_wr_en = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [4:0] strap);
        @(negedge clk);
        rst_n = 1'b0;
        phy_addr_strap = strap;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic t_reset_nonzero();
        do_reset(5'h03);
        chk("R1 reg after reset", reg_rd_data, 16'h0000);
        chk("R1 pulse idle", an_restart_pulse, 1'b0);
        chk("R2 oe all on", mii_oe, 7'h7F);
        chk("R2 passthrough", {line_tx_en, line_txd}, {mac_tx_en, mac_txd});
    endtask

    task automatic t_isolate();
        @(negedge clk);
        mac_tx_en = 1'b1; mac_tx_er = 1'b1; mac_txd = 4'hA;
        #1;
        chk("R2 tx passes", {line_tx_en, line_tx_er, line_txd}, 6'h3A);
        wr(16'h0400);
        chk("R2 oe off", mii_oe, 7'h00);
        chk("R2 tx ignored", {line_tx_en, line_tx_er, line_txd}, 6'h00);
        chk("R3 readable isolated", reg_rd_data, 16'h0400);
        wr(16'h0100);
        chk("R3 iso cleared by write", reg_rd_data, 16'h0100);
        chk("R3 oe back on", mii_oe, 7'h7F);
        @(negedge clk);
        mac_tx_en = 1'b0; mac_tx_er = 1'b0; mac_txd = 4'h0;
    endtask

    task automatic t_restart();
        wr(16'h0200);
        chk("R4 bit set", reg_rd_data[9], 1'b1);
        chk("R4 no pulse yet", an_restart_pulse, 1'b0);
        tick();
        chk("R4 pulse", an_restart_pulse, 1'b1);
        tick();
        chk("R4 pulse ends", an_restart_pulse, 1'b0);
        chk("R4 bit clears", reg_rd_data[9], 1'b0);
        // writing 0 does not cancel a pending restart
        wr(16'h0200);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_data = 16'h0000;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
        chk("R4 zero write keeps pulse", an_restart_pulse, 1'b1);
        tick();
        chk("R4 clears after", reg_rd_data[9], 1'b0);
    endtask

    task automatic t_restart_overlap();
        wr(16'h0200);
        tick();
        chk("R5 first pulse", an_restart_pulse, 1'b1);
        reg_wr_en = 1'b1; reg_wr_data = 16'h0200;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
        chk("R5 pulse low", an_restart_pulse, 1'b0);
        chk("R5 bit kept", reg_rd_data[9], 1'b1);
        tick();
        chk("R5 second pulse", an_restart_pulse, 1'b1);
        tick();
        chk("R5 done", {an_restart_pulse, reg_rd_data[9]}, 2'b00);
    endtask

    task automatic t_duplex();
        wr(16'h0100);
        an_result_full = 1'b0; #1;
        chk("R6 select full", duplex_full, 1'b1);
        wr(16'h1100);
        chk("R6 an overrides select", duplex_full, 1'b0);
        an_result_full = 1'b1; #1;
        chk("R6 an full", duplex_full, 1'b1);
        wr(16'h1000);
        chk("R6 an full sel 0", duplex_full, 1'b1);
        wr(16'h0000);
        chk("R6 select half", duplex_full, 1'b0);
    endtask

    task automatic t_coltest();
        core_col = 1'b1; #1;
        chk("R7 normal col", mii_col, 1'b1);
        wr(16'h0080);
        chk("R7 echo idle", mii_col, 1'b0);
        @(negedge clk); mac_tx_en = 1'b1; #1;
        chk("R7 not before edge", mii_col, 1'b0);
        tick();
        chk("R7 asserted", mii_col, 1'b1);
        @(negedge clk); mac_tx_en = 1'b0;
        tick();
        chk("R7 deasserted", mii_col, 1'b0);
        // isolate write while echo high
        @(negedge clk); mac_tx_en = 1'b1;
        tick();
        chk("R7 re-asserted", mii_col, 1'b1);
        wr(16'h0480);
        tick();
        chk("R8 isolated echo low", mii_col, 1'b0);
        repeat (3) tick();
        chk("R8 stays low", mii_col, 1'b0);
        @(negedge clk); mac_tx_en = 1'b0; core_col = 1'b0;
        wr(16'h0000);
    endtask

    task automatic t_reserved();
        wr(16'hFFFF);
        chk("R9 reserved low", reg_rd_data & 16'hE87F, 16'h0000);
        chk("R9 implemented set", reg_rd_data & 16'h1780, 16'h1780);
        wr(16'h0000);
        repeat (3) tick();
    endtask

    task automatic t_reset_zero();
        do_reset(5'h00);
        chk("R1 iso from zero strap", reg_rd_data, 16'h0400);
        chk("R1 oe off", mii_oe, 7'h00);
        do_reset(5'h10);
        chk("R1 iso clear nonzero", reg_rd_data, 16'h0000);
    endtask

    initial begin
        t_reset_nonzero();
        t_isolate();
        t_restart();
        t_restart_overlap();
        t_duplex();
        t_coltest();
        t_reserved();
        t_reset_zero();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule